// File: doc/BRIEF.md
# Coherent Snapshot Register Port for Timekeeping

This block sits between a byte-serial register bus and a set of live timekeeping counters. It holds a frozen copy of the time and date bytes, so that a host reading several bytes in a row gets values that belong together. The counters can tick in the middle of such a read without tearing it. The bus framing itself is decoded elsewhere. This block only sees start and stop indications, a byte-written strobe, an acknowledge strobe and a byte-read strobe.

A transfer opens with a start. The first byte written after a start loads the register pointer. Each later byte is data and is committed at its acknowledge strobe. Bytes aimed at the time and date range go out on a one-cycle write port to the counter block. A commit to address 0, the seconds byte, also tells that block to clear its sub-second divider. Addresses above the time range are configuration bytes, such as alarm and control bytes, which this block stores itself. The pointer steps after every data byte and every read, and it wraps to address 0.

Top module: `snap_regif`

## Requirements
- R1: A read of an address below TIME_REGS returns the frozen copy, not the live counter input. A change of the live input with no refresh event leaves the copy unchanged.
- R2: A start strobe refreshes the copy from the live input sampled on the same clock edge.
- R3: A stop strobe refreshes the copy from the live input sampled on the same clock edge. A read issued after it, with no new start, returns the refreshed value.
- R4: When the pointer steps from NUM_REGS-1 to 0, the copy is refreshed on that edge, so the next read of address 0 returns the live value of that moment.
- R5: A data byte for a time address appears on tw_en_o/tw_addr_o/tw_data_o for exactly one cycle, in the cycle after its acknowledge strobe. The byte strobe alone produces nothing on that port.
- R6: A committed data byte at address 0 raises sec_rst_o in the same cycle as tw_en_o. No other address raises it.
- R7: The pointer increments by one after every read and every committed data byte.
- R8: The first byte acknowledged after a start loads the pointer and is not committed as data. A pointer byte greater than NUM_REGS-1 loads 0.
- R9: Data bytes for addresses TIME_REGS to NUM_REGS-1 are kept in local storage and read back unchanged. They never appear on the time write port.
- R10: After reset all outputs are 0, the pointer is 0 and the frozen copy is all zeros.
- R11: rd_valid_o and rd_byte_o answer a read strobe in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_start_i | input | 1 | Start condition seen on the bus (one-cycle pulse) |
| bus_stop_i | input | 1 | Stop condition seen on the bus (one-cycle pulse) |
| wr_stb_i | input | 1 | A byte from the host has been received |
| wr_byte_i | input | 8 | Received byte, valid with wr_stb_i |
| ack_stb_i | input | 1 | Acknowledge point of the last received byte |
| rd_stb_i | input | 1 | Host requests the byte at the pointer |
| live_time_i | input | TIME_REGS*8 | Live counter bytes, byte k at bits 8k+7..8k |
| rd_valid_o | output | 1 | Read data valid |
| rd_byte_o | output | 8 | Read data |
| tw_en_o | output | 1 | Write of a time byte to the counter block |
| tw_addr_o | output | $clog2(NUM_REGS) | Address of that write |
| tw_data_o | output | 8 | Data of that write |
| sec_rst_o | output | 1 | Clear the sub-second divider |

## Verification
Some behaviour is checked on every cycle by the bound checker. These checks cover the one-cycle shape of the time write port and its link to the acknowledge strobe, and seconds clear appearing only together with a write to address 0. They also cover read latency, the copy staying unchanged between refresh events, and the copy matching the live input after a start. Other behaviour needs a sequence of bus activity and is left to the bench scenarios. These are pointer loading and clamping, auto-increment across reads and writes, refresh on stop and on pointer wrap, and read-back of configuration bytes. Each scenario ticks the live input between events and checks whether the old or the new value is returned.

// File: rtl/snap_pkg.sv
package snap_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] reg_byte_t;
  typedef enum logic {PH_POINTER = 1'b0, PH_DATA = 1'b1} wphase_e;
endpackage

// File: rtl/snap_ptr.sv
module snap_ptr #(
  parameter int NUM_REGS = 16,
  parameter int AW       = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [7:0]    load_val_i,
  input  logic          step_i,
  output logic [AW-1:0] ptr_o,
  output logic          wrap_o
);
  localparam logic [AW-1:0] LAST = AW'(NUM_REGS - 1);

  logic [AW-1:0] ptr_q;

  assign wrap_o = step_i && !load_i && (ptr_q == LAST);
  assign ptr_o  = ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (load_i) begin
      if (load_val_i > 8'(NUM_REGS - 1)) ptr_q <= '0;
      else                               ptr_q <= AW'(load_val_i);
    end else if (step_i) begin
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/snap_shadow.sv
module snap_shadow #(
  parameter int NBYTES = 7,
  parameter int IW     = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reload_i,
  input  logic [NBYTES*8-1:0] live_i,
  input  logic                rd_en_i,
  input  logic [IW-1:0]       rd_idx_i,
  output logic [NBYTES*8-1:0] snap_o,
  output logic [7:0]          rd_byte_o
);
  logic [7:0] snap_q [NBYTES];
  logic [7:0] rd_q;

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)           snap_q[g] <= '0;
      else if (reload_i) snap_q[g] <= live_i[g*8 +: 8];
    end
    assign snap_o[g*8 +: 8] = snap_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst)          rd_q <= '0;
    else if (rd_en_i) rd_q <= snap_q[rd_idx_i];
  end

  assign rd_byte_o = rd_q;
endmodule

// File: rtl/snap_cfgfile.sv
module snap_cfgfile #(
  parameter int DEPTH = 9,
  parameter int CIW   = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we_i,
  input  logic [CIW-1:0] waddr_i,
  input  logic [7:0]     wdata_i,
  input  logic           re_i,
  input  logic [CIW-1:0] raddr_i,
  output logic [7:0]     rdata_o
);
  logic [7:0] mem [DEPTH];
  logic [7:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_q <= '0;
    else if (re_i) rdata_q <= mem[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/snap_regif.sv
module snap_regif #(
  parameter int NUM_REGS  = 16,
  parameter int TIME_REGS = 7,
  parameter int AW        = $clog2(NUM_REGS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_start_i,
  input  logic                   bus_stop_i,
  input  logic                   wr_stb_i,
  input  logic [7:0]             wr_byte_i,
  input  logic                   ack_stb_i,
  input  logic                   rd_stb_i,
  input  logic [TIME_REGS*8-1:0] live_time_i,
  output logic                   rd_valid_o,
  output logic [7:0]             rd_byte_o,
  output logic                   tw_en_o,
  output logic [AW-1:0]          tw_addr_o,
  output logic [7:0]             tw_data_o,
  output logic                   sec_rst_o
);
  import snap_pkg::*;

  localparam int CFG_DEPTH = NUM_REGS - TIME_REGS;
  localparam int SIW = (TIME_REGS > 1) ? $clog2(TIME_REGS) : 1;
  localparam int CIW = (CFG_DEPTH > 1) ? $clog2(CFG_DEPTH) : 1;
  localparam logic [AW-1:0] TIME_LIM = AW'(TIME_REGS);

  wphase_e   phase_q;
  logic      pend_q;
  reg_byte_t pend_byte_q;
  logic      commit, ptr_load, data_commit, is_time, ptr_step;
  logic      wrap_evt, reload;
  logic [AW-1:0] ptr;
  logic [TIME_REGS*8-1:0] snap_flat;
  logic [7:0] shd_byte, cfg_byte;
  logic       sel_cfg_q, rd_valid_q;
  logic       tw_en_q, sec_rst_q;
  logic [AW-1:0] tw_addr_q;
  reg_byte_t  tw_data_q;

  assign commit      = ack_stb_i && pend_q;
  assign ptr_load    = commit && (phase_q == PH_POINTER);
  assign data_commit = commit && (phase_q == PH_DATA);
  assign is_time     = (ptr < TIME_LIM);
  assign ptr_step    = data_commit || rd_stb_i;
  assign reload      = bus_start_i || bus_stop_i || wrap_evt;

  // Transfer phase and pending received byte
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q     <= PH_POINTER;
      pend_q      <= 1'b0;
      pend_byte_q <= '0;
    end else begin
      if (bus_start_i || bus_stop_i) begin
        phase_q <= PH_POINTER;
        pend_q  <= 1'b0;
      end else begin
        if (ptr_load) phase_q <= PH_DATA;
        if (wr_stb_i) begin
          pend_q      <= 1'b1;
          pend_byte_q <= wr_byte_i;
        end else if (ack_stb_i) begin
          pend_q <= 1'b0;
        end
      end
    end
  end

  snap_ptr #(.NUM_REGS(NUM_REGS), .AW(AW)) u_ptr (
    .clk        (clk),
    .rst        (rst),
    .load_i     (ptr_load),
    .load_val_i (pend_byte_q),
    .step_i     (ptr_step),
    .ptr_o      (ptr),
    .wrap_o     (wrap_evt)
  );

  snap_shadow #(.NBYTES(TIME_REGS), .IW(SIW)) u_shadow (
    .clk       (clk),
    .rst       (rst),
    .reload_i  (reload),
    .live_i    (live_time_i),
    .rd_en_i   (rd_stb_i && is_time),
    .rd_idx_i  (SIW'(ptr)),
    .snap_o    (snap_flat),
    .rd_byte_o (shd_byte)
  );

  snap_cfgfile #(.DEPTH(CFG_DEPTH), .CIW(CIW)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .we_i    (data_commit && !is_time),
    .waddr_i (CIW'(ptr - TIME_LIM)),
    .wdata_i (pend_byte_q),
    .re_i    (rd_stb_i && !is_time),
    .raddr_i (CIW'(ptr - TIME_LIM)),
    .rdata_o (cfg_byte)
  );

  // Read return and time write port
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_q <= 1'b0;
      sel_cfg_q  <= 1'b0;
      tw_en_q    <= 1'b0;
      sec_rst_q  <= 1'b0;
      tw_addr_q  <= '0;
      tw_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_stb_i;
      if (rd_stb_i) sel_cfg_q <= !is_time;
      tw_en_q   <= data_commit && is_time;
      sec_rst_q <= data_commit && (ptr == '0);
      if (data_commit && is_time) begin
        tw_addr_q <= ptr;
        tw_data_q <= pend_byte_q;
      end
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_byte_o  = sel_cfg_q ? cfg_byte : shd_byte;
  assign tw_en_o    = tw_en_q;
  assign tw_addr_o  = tw_addr_q;
  assign tw_data_o  = tw_data_q;
  assign sec_rst_o  = sec_rst_q;
endmodule

// File: rtl/snap_regif_chk.sv
module snap_regif_chk #(
  parameter int AW = 4,
  parameter int TW = 56
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_start_i,
  input logic          bus_stop_i,
  input logic          ack_stb_i,
  input logic          rd_stb_i,
  input logic [TW-1:0] live_time_i,
  input logic          rd_valid_o,
  input logic          tw_en_o,
  input logic [AW-1:0] tw_addr_o,
  input logic          sec_rst_o,
  input logic          wrap_evt,
  input logic [TW-1:0] snap_flat
);
  // R5
  tw_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    tw_en_o |-> $past(ack_stb_i));
  // R5
  tw_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tw_en_o |=> !tw_en_o);
  // R6
  sec_rst_addr_chk: assert property (@(posedge clk) disable iff (rst)
    sec_rst_o |-> (tw_en_o && tw_addr_o == '0));
  // R11
  rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    rd_stb_i |=> rd_valid_o);
  // R11
  rd_no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o |-> $past(rd_stb_i));
  // R1
  snap_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_start_i || bus_stop_i || wrap_evt) |=> $stable(snap_flat));
  // R2
  snap_start_chk: assert property (@(posedge clk) disable iff (rst)
    bus_start_i |=> (snap_flat == $past(live_time_i)));
endmodule

bind snap_regif snap_regif_chk #(.AW(AW), .TW(TIME_REGS*8)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_start_i (bus_start_i),
  .bus_stop_i  (bus_stop_i),
  .ack_stb_i   (ack_stb_i),
  .rd_stb_i    (rd_stb_i),
  .live_time_i (live_time_i),
  .rd_valid_o  (rd_valid_o),
  .tw_en_o     (tw_en_o),
  .tw_addr_o   (tw_addr_o),
  .sec_rst_o   (sec_rst_o),
  .wrap_evt    (wrap_evt),
  .snap_flat   (snap_flat)
);

// File: tb/snap_regif_tb.sv
`timescale 1ns/1ps
module snap_regif_tb;
  localparam int NR = 16;
  localparam int TR = 7;
  localparam int AW = $clog2(NR);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_start = 0, bus_stop = 0, wr_stb = 0, ack_stb = 0, rd_stb = 0;
  logic [7:0] wr_byte = '0;
  logic [TR*8-1:0] live = '0;
  logic rd_valid, tw_en, sec_rst;
  logic [7:0] rd_byte, tw_data;
  logic [AW-1:0] tw_addr;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       cap_en, cap_sec;
  logic [AW-1:0] cap_addr;
  logic [7:0] cap_data;

  always #10 clk = ~clk;

  snap_regif #(.NUM_REGS(NR), .TIME_REGS(TR)) u_dut (
    .clk(clk), .rst(rst), .bus_start_i(bus_start), .bus_stop_i(bus_stop),
    .wr_stb_i(wr_stb), .wr_byte_i(wr_byte), .ack_stb_i(ack_stb),
    .rd_stb_i(rd_stb), .live_time_i(live), .rd_valid_o(rd_valid),
    .rd_byte_o(rd_byte), .tw_en_o(tw_en), .tw_addr_o(tw_addr),
    .tw_data_o(tw_data), .sec_rst_o(sec_rst)
  );

  function automatic logic [7:0] lv(int k, int i);
    return 8'(k * 16 + i + 1);
  endfunction

  task automatic set_live(int k);
    for (int i = 0; i < TR; i++) live[i*8 +: 8] = lv(k, i);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected read bytes as the design returns them
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R11: actual unexpected read %0h expected none", rd_byte);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rd_byte !== e) begin
          fails++;
          $display("FAIL %s: actual %0h expected %0h", t, rd_byte, e);
        end
      end
    end
  end

  task automatic pulse_start();
    @(negedge clk) bus_start = 1;
    @(negedge clk) bus_start = 0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) bus_stop = 1;
    @(negedge clk) bus_stop = 0;
  endtask

  // Byte strobe, idle gap, then acknowledge; captures the time write port
  task automatic send_byte(logic [7:0] b);
    @(negedge clk) begin wr_stb = 1; wr_byte = b; end
    @(negedge clk) wr_stb = 0;
    chk("R5 no write before ack", tw_en, 0);
    @(negedge clk) ack_stb = 1;
    @(negedge clk) begin
      ack_stb  = 0;
      cap_en   = tw_en;
      cap_sec  = sec_rst;
      cap_addr = tw_addr;
      cap_data = tw_data;
    end
  endtask

  task automatic read_byte(logic [7:0] e, string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk) rd_stb = 1;
    @(negedge clk) rd_stb = 0;
  endtask

  task automatic finish_run();
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R11: actual %0d reads missing expected 0", exp_q.size());
    end
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk("R10 rd_valid", rd_valid, 0);
    chk("R10 tw_en", tw_en, 0);
    chk("R10 sec_rst", sec_rst, 0);
    chk("R10 rd_byte", rd_byte, 0);
    set_live(1);
    read_byte(8'h00, "R10 zero snapshot at ptr 0");

    // R1/R7: tick during frozen read, sequential addresses
    pulse_start();
    send_byte(8'h00);
    chk("R8 pointer byte not data", cap_en, 0);
    set_live(2);
    for (int i = 0; i < TR; i++) read_byte(lv(1, i), "R1 R7 frozen sequential read");
    pulse_stop();

    // R2: start refresh
    set_live(3);
    pulse_start();
    send_byte(8'h04);
    set_live(4);
    read_byte(lv(3, 4), "R2 start refresh");
    pulse_stop();
    // R3: stop refresh, read continues at ptr 5 without a start
    set_live(5);
    read_byte(lv(4, 5), "R3 stop refresh");

    // R5/R7: time writes
    pulse_start();
    send_byte(8'h02);
    send_byte(8'h45);
    chk("R5 tw_en", cap_en, 1);
    chk("R5 tw_addr", cap_addr, 2);
    chk("R5 tw_data", cap_data, 8'h45);
    chk("R6 no sec_rst at addr 2", cap_sec, 0);
    @(negedge clk);
    chk("R5 single pulse", tw_en, 0);
    send_byte(8'h12);
    chk("R7 write increments", cap_addr, 3);
    chk("R5 second data", cap_data, 8'h12);
    pulse_stop();
    // R6: seconds write
    pulse_start();
    send_byte(8'h00);
    send_byte(8'h00);
    chk("R6 tw_en", cap_en, 1);
    chk("R6 sec_rst", cap_sec, 1);
    chk("R6 addr", cap_addr, 0);
    pulse_stop();

    // R9: configuration bytes
    pulse_start();
    send_byte(8'h09);
    send_byte(8'hA5);
    chk("R9 cfg not on time port", cap_en, 0);
    send_byte(8'h5A);
    chk("R9 cfg not on time port", cap_en, 0);
    pulse_stop();
    pulse_start();
    send_byte(8'h0F);
    send_byte(8'hC3);
    pulse_stop();
    pulse_start();
    send_byte(8'h09);
    read_byte(8'hA5, "R9 cfg readback");
    read_byte(8'h5A, "R9 cfg readback");
    pulse_stop();

    // R4: wrap refresh
    set_live(6);
    pulse_start();
    send_byte(8'h0F);
    set_live(7);
    read_byte(8'hC3, "R9 last cfg byte");
    read_byte(lv(7, 0), "R4 wrap refresh");
    read_byte(lv(7, 1), "R4 after wrap");
    pulse_stop();

    // R8: out-of-range pointer loads 0
    pulse_start();
    send_byte(8'h40);
    chk("R8 oversize pointer not data", cap_en, 0);
    read_byte(lv(7, 0), "R8 pointer clamp");
    pulse_stop();

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule